// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block keeps the pending state for eight interrupt request lines. Each line is set to edge or level sensitivity by one bit of a trigger-mode register. Every clock the block samples all request inputs and stores each line's level from that cycle. From the sampled level, the stored level and the line's mode, it computes the next pending bit. Priority selection and masking are done by logic downstream, which reads the pending vector and the trigger-mode vector.

Software writes the trigger-mode register through a byte-wide strobe-qualified port. A writable-bit mask is fixed for each instance and filters every write, so hard-wired edge lines cannot become level lines. When an interrupt is serviced, an acknowledge strobe carries a 3-bit line index. A reinitialise strobe returns the edge side of the latch to a clean state and leaves level-driven state alone. All of these are plain control pins: they have no handshake, and a strobe acts in the cycle it is high.

Top module: `edge_level_req_latch`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level) has its pending bit equal, one cycle later, to the request input sampled in the previous cycle.
- R2: A line whose trigger-mode bit is 0 (edge) sets its pending bit one cycle after a cycle in which its input is 1 and its stored previous level is 0.
- R3: A low input never clears a pending bit of an edge-mode line.
- R4: The stored previous level of every line takes the sampled input each cycle, so an edge line held high latches only once.
- R5: A trigger-mode write (mode_wr_en high) stores mode_wr_data AND WR_MASK. The default mask is 8'hF8. A second instance built with 8'hDE keeps only the bits of 8'hDE.
- R6: An acknowledge (ack_valid high, ack_idx = line number 0..7) clears that line's pending bit only when the line is in edge mode. A level-mode pending bit is not affected.
- R7: A reinitialise strobe clears every stored previous level and every edge-mode pending bit, and keeps level-mode pending bits. An edge input still high afterwards latches again on the next cycle.
- R8: After reset the trigger-mode register and the pending vector are all zeros, so every line starts in edge mode.
- R9: When a rising sample arrives on an edge line in the same cycle as an acknowledge of that line, or as a reinitialise, the line ends up pending.
- R10: An acknowledge changes only the indexed line. The pending bits of all other lines are not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Interrupt request levels, sampled every clock |
| mode_wr_en | input | 1 | Trigger-mode write strobe |
| mode_wr_data | input | 8 | Trigger-mode write value (1 = level, 0 = edge) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Line index acknowledged |
| reinit | input | 1 | Reinitialise strobe |
| pending | output | 8 | Pending request vector |
| trig_mode | output | 8 | Current trigger-mode register |

## Verification
The edge path is tested with isolated rising pulses, with a line held high across an acknowledge, and with a line that falls after it latched. Together these separate true edge detection from plain level sampling. The level path is tested by raising and dropping a level line and by acknowledging it while it is high, which shows whether acknowledge wrongly clears level bits. Reinitialise is issued while one edge line and one level line are both high, which separates the two kinds of bit and also shows that the stored previous levels were cleared. Coincident rise-plus-acknowledge and rise-plus-reinitialise patterns fix the precedence rule, and all-ones writes to two instances with different masks expose the write filter.

// File: rtl/irql_pkg.sv
package irql_pkg;
  localparam int unsigned IRQL_DEF_LINES = 8;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irql_mode_reg.sv
module irql_mode_reg #(
  parameter int unsigned      N_LINES = irql_pkg::IRQL_DEF_LINES,
  parameter logic [N_LINES-1:0] WR_MASK = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] mode_q
);
  // Masked bits can never hold a 1, so they stay edge mode permanently.
  always_ff @(posedge clk) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= wr_data & WR_MASK;
  end
endmodule

// File: rtl/irql_line.sv
module irql_line
  import irql_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req,
  input  trig_e mode,
  input  logic  ack_hit,
  input  logic  reinit,
  output logic  pend,
  output logic  prev
);
  logic rise;
  logic clr_edge;

  assign rise     = req & ~prev;
  assign clr_edge = ack_hit | reinit;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= reinit ? 1'b0 : req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (mode == TRIG_LEVEL) begin
      pend <= req;
    end else begin
      // A set caused by the input takes precedence over clears in the same cycle.
      pend <= rise | (pend & ~clr_edge);
    end
  end
endmodule

// File: rtl/edge_level_req_latch.sv
module edge_level_req_latch
  import irql_pkg::*;
#(
  parameter int unsigned        N_LINES = IRQL_DEF_LINES,
  parameter logic [N_LINES-1:0] WR_MASK = 8'hF8,
  localparam int unsigned       IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_in,
  input  logic               mode_wr_en,
  input  logic [N_LINES-1:0] mode_wr_data,
  input  logic               ack_valid,
  input  logic [IDX_W-1:0]   ack_idx,
  input  logic               reinit,
  output logic [N_LINES-1:0] pending,
  output logic [N_LINES-1:0] trig_mode
);
  logic [N_LINES-1:0] ack_hit;
  logic [N_LINES-1:0] prev_lvl;

  irql_mode_reg #(.N_LINES(N_LINES), .WR_MASK(WR_MASK)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_wr_en),
    .wr_data (mode_wr_data),
    .mode_q  (trig_mode)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign ack_hit[g] = ack_valid && (ack_idx == IDX_W'(g));

    irql_line u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_in[g]),
      .mode    (trig_e'(trig_mode[g])),
      .ack_hit (ack_hit[g]),
      .reinit  (reinit),
      .pend    (pending[g]),
      .prev    (prev_lvl[g])
    );
  end
endmodule

// File: rtl/irql_checker.sv
module irql_checker #(
  parameter int unsigned        N_LINES = 8,
  parameter logic [N_LINES-1:0] WR_MASK = '1,
  localparam int unsigned       IDX_W   = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] req_in,
  input logic               ack_valid,
  input logic [IDX_W-1:0]   ack_idx,
  input logic               reinit,
  input logic [N_LINES-1:0] trig_mode,
  input logic [N_LINES-1:0] pending,
  input logic [N_LINES-1:0] prev_lvl
);
  a_r5_mask_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode & ~WR_MASK) == '0);

  a_r7_reinit_prev: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> prev_lvl == '0);

  for (genvar k = 0; k < N_LINES; k++) begin : g_chk
    a_r1_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      trig_mode[k] |=> pending[k] == $past(req_in[k]));

    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_mode[k] && req_in[k] && !prev_lvl[k]) |=> pending[k]);

    a_r3_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_mode[k] && pending[k] && !reinit &&
       !(ack_valid && ack_idx == IDX_W'(k))) |=> pending[k]);

    a_r4_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      !reinit |=> prev_lvl[k] == $past(req_in[k]));

    a_r6_ack_clears_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_mode[k] && ack_valid && ack_idx == IDX_W'(k) &&
       !(req_in[k] && !prev_lvl[k])) |=> !pending[k]);
  end
endmodule

bind edge_level_req_latch irql_checker #(.N_LINES(N_LINES), .WR_MASK(WR_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_in    (req_in),
  .ack_valid (ack_valid),
  .ack_idx   (ack_idx),
  .reinit    (reinit),
  .trig_mode (trig_mode),
  .pending   (pending),
  .prev_lvl  (prev_lvl)
);

// File: tb/tb_edge_level_req_latch.sv
`timescale 1ns/1ps
module tb_edge_level_req_latch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_in;
  logic       mode_wr_en;
  logic [7:0] mode_wr_data;
  logic       ack_valid;
  logic [2:0] ack_idx;
  logic       reinit;
  logic [7:0] pending;
  logic [7:0] trig_mode;
  logic       s_wr_en;
  logic [7:0] s_pending;
  logic [7:0] s_mode;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  edge_level_req_latch dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .mode_wr_en(mode_wr_en),
    .mode_wr_data(mode_wr_data), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .reinit(reinit), .pending(pending), .trig_mode(trig_mode)
  );

  edge_level_req_latch #(.WR_MASK(8'hDE)) dut_sec (
    .clk(clk), .rst_n(rst_n), .req_in(8'h00), .mode_wr_en(s_wr_en),
    .mode_wr_data(8'hFF), .ack_valid(1'b0), .ack_idx(3'd0),
    .reinit(1'b0), .pending(s_pending), .trig_mode(s_mode)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply the inputs, clock once, and return 1 ns after the edge.
  task automatic tick(input logic [7:0] r, input logic ack = 1'b0,
                      input logic [2:0] idx = 3'd0, input logic ri = 1'b0);
    req_in = r; ack_valid = ack; ack_idx = idx; reinit = ri;
    @(posedge clk); #1;
    ack_valid = 1'b0; reinit = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 pending after reset", pending, 8'h00);
    check("R8 mode after reset", trig_mode, 8'h00);
  endtask

  task automatic t_edge;
    tick(8'h00);
    tick(8'h01); check("R2 rising edge latches", pending, 8'h01);
    tick(8'h01, 1'b1, 3'd0); check("R6 edge ack clears", pending, 8'h00);
    tick(8'h01); check("R4 held high no relatch", pending, 8'h00);
    tick(8'h00);
    tick(8'h02); check("R2 second line edge", pending, 8'h02);
    tick(8'h00); check("R3 low keeps edge pending", pending, 8'h02);
  endtask

  task automatic t_ack_other;
    tick(8'h00, 1'b1, 3'd5); check("R10 ack other line no effect", pending, 8'h02);
    tick(8'h00, 1'b1, 3'd1); check("R10 ack indexed line", pending, 8'h00);
  endtask

  task automatic t_mask;
    mode_wr_data = 8'hFF; mode_wr_en = 1'b1; s_wr_en = 1'b1;
    @(posedge clk); #1;
    mode_wr_en = 1'b0; s_wr_en = 1'b0;
    check("R5 primary mask F8", trig_mode, 8'hF8);
    check("R5 secondary mask DE", s_mode, 8'hDE);
  endtask

  task automatic t_level;
    tick(8'h08); check("R1 level high sets", pending, 8'h08);
    tick(8'h08, 1'b1, 3'd3); check("R6 level ack ignored", pending, 8'h08);
    tick(8'h00); check("R1 level low clears", pending, 8'h00);
  endtask

  task automatic t_reinit;
    tick(8'h09); check("R2/R1 mixed pending", pending, 8'h09);
    tick(8'h09, 1'b0, 3'd0, 1'b1); check("R7 reinit clears edge keeps level", pending, 8'h08);
    tick(8'h09); check("R7 held edge relatches after reinit", pending, 8'h09);
  endtask

  task automatic t_collide;
    tick(8'h00, 1'b1, 3'd0); check("R6 clear before collision", pending, 8'h00);
    tick(8'h01, 1'b1, 3'd0); check("R9 rise beats ack", pending, 8'h01);
    tick(8'h00, 1'b1, 3'd0);
    tick(8'h01, 1'b0, 3'd0, 1'b1); check("R9 rise beats reinit", pending, 8'h01);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_in = '0; mode_wr_en = 1'b0; mode_wr_data = '0;
    ack_valid = 1'b0; ack_idx = '0; reinit = 1'b0; s_wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_edge();
    t_ack_other();
    t_mask();
    t_level();
    t_reinit();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule